// File: doc/BRIEF.md
# Nine-Bit Multiprocessor Serial Port

This block is an asynchronous serial transmitter and receiver. Its frame is fixed at eleven bits, and it carries a ninth data bit. Software drives it through a small control register and a transmit strobe. The register holds:

- address filtering enable
- outgoing ninth bit
- rate select
- receive enable
- transmit-done flag
- receive-done flag
- received ninth bit

Writing a byte starts a frame on `txd`. The receiver oversamples `rxd` sixteen times per bit, detects the falling edge of a start bit, and decides each bit by a majority of three mid-bit samples.

On a multi-drop line, the address filter lets a node ignore data frames: a frame whose ninth bit is 0 is thrown away. A frame is also dropped whenever the previous one has not yet been acknowledged. A dropped frame leaves the buffer, the received ninth bit and the flag untouched. After the last sampled bit, the receiver always goes back to hunting for a start edge.

The bit time is a fixed division of the system clock. It is one of two rates, selected by a control bit. Both transmit-done and receive-done drive a single interrupt request.

Top module: `ninebit_uart`

## Requirements
- R1: A transmitted frame on `txd` is one low start bit, then the 8 data bits least significant bit first, then the ninth bit taken from the stored `ctl_tb8`, then one high stop bit; `txd` is high whenever no frame is in progress.
- R2: With default parameters, one bit lasts 32 clock cycles when the stored `ctl_smod` is 1 and 64 cycles when it is 0; the start bit begins in the cycle after the clock edge that samples `tx_we`.
- R3: A `tx_we` pulse while the transmitter is idle starts a frame; a `tx_we` pulse during a frame is ignored and does not alter the frame in progress.
- R4: `ti` becomes 1 in the same cycle in which the stop bit appears on `txd`.
- R5: `ti` and `ri` are cleared only by a control write (`ctl_we` with the flag input at 0); the hardware only ever sets them.
- R6: With `ctl_sm2` stored as 0 and `ri` at 0, a received frame loads its 8 data bits into `rx_data` and its ninth bit into `rb8`, and sets `ri`.
- R7: With `ctl_sm2` stored as 1, a frame whose ninth bit is 0 is discarded with `rx_data`, `rb8` and `ri` unchanged; a frame whose ninth bit is 1 is accepted.
- R8: While `ri` is 1, every received frame is discarded, and `rx_data` and `rb8` keep their values.
- R9: After the final bit of a frame, accepted or not, the receiver resumes searching for a falling edge, so a frame that follows within one bit time is received.
- R10: A low pulse on `rxd` that is shorter than half a bit is read as a start bit that samples high; reception is aborted with no effect on `ri`, `rx_data` or `rb8`, and the next frame is still received.
- R11: While the stored `ctl_ren` is 0, no reception starts and `ri` is not set.
- R12: `irq` is 1 exactly when `ti` or `ri` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_sm2 | input | 1 | Address filter enable (write data) |
| ctl_tb8 | input | 1 | Ninth bit for transmit (write data) |
| ctl_smod | input | 1 | Rate select, 1 = fast (write data) |
| ctl_ren | input | 1 | Receive enable (write data) |
| ctl_ti | input | 1 | Transmit-done flag value (write data) |
| ctl_ri | input | 1 | Receive-done flag value (write data) |
| ctl_rb8 | input | 1 | Received ninth bit value (write data) |
| tx_we | input | 1 | Transmit buffer write, starts a frame |
| tx_data | input | 8 | Byte to transmit |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive-done flag |
| rb8 | output | 1 | Ninth bit of the last accepted frame |
| rx_data | output | 8 | Byte of the last accepted frame |
| irq | output | 1 | Combined serial interrupt request |

## Verification
The bench builds the block with its default parameters: sixteen samples per bit, and a sample tick every two clocks at the fast rate and every four at the slow rate. This gives bit times of 32 and 64 cycles. A full frame then takes at most about seven hundred cycles. That is short enough to run, in one test, both rates and every acceptance case: filter off, filter on with either ninth bit, and a pending flag. It also covers a write during a busy frame, two frames with little gap between them, a glitch on the line, and reception disabled. Running `txd` back into `rxd` ties the receiver's majority sampling to a transmitter whose bit edges the reference model predicts to the cycle.

// File: rtl/u9_pkg.sv
package u9_pkg;

    localparam int DATA_W  = 8;
    // start + data + ninth + stop
    localparam int FRAME_W = DATA_W + 3;
    localparam int IDX_W   = $clog2(FRAME_W + 1);

    typedef enum logic {
        RX_HUNT  = 1'b0,
        RX_FRAME = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ninth;
    } rx_word_t;

    typedef struct packed {
        logic sm2;
        logic tb8;
        logic smod;
        logic ren;
    } ctl_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/u9_baud.sv
module u9_baud #(
    parameter int SAMPLE_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic smod,
    output logic tick
);
    localparam int CW = $clog2(2 * SAMPLE_DIV + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // fast rate: a sample every SAMPLE_DIV clocks, slow rate: twice that
    assign lim  = smod ? CW'(SAMPLE_DIV - 1) : CW'(2 * SAMPLE_DIV - 1);
    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/u9_tx.sv
module u9_tx
    import u9_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int SAMPLE_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  logic              ninth,
    input  logic              smod,
    output logic              txd,
    output logic              busy,
    output logic              stop_begin
);
    localparam int BIT_FAST = OVERSAMPLE * SAMPLE_DIV;
    localparam int BIT_SLOW = 2 * BIT_FAST;
    localparam int CW       = $clog2(BIT_SLOW);

    logic [FRAME_W-1:0] sh;
    logic [CW-1:0]      cnt;
    logic [CW-1:0]      lim;
    logic [IDX_W-1:0]   idx;
    logic               bit_end;

    assign bit_end    = busy && (cnt == lim);
    assign stop_begin = bit_end && (idx == IDX_W'(FRAME_W - 2));
    assign txd        = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sh   <= '1;
            cnt  <= '0;
            lim  <= '0;
            idx  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                sh   <= {1'b1, ninth, data, 1'b0};
                cnt  <= '0;
                idx  <= '0;
                lim  <= smod ? CW'(BIT_FAST - 1) : CW'(BIT_SLOW - 1);
            end
        end else if (bit_end) begin
            cnt <= '0;
            sh  <= {1'b1, sh[FRAME_W-1:1]};
            idx <= idx + 1'b1;
            if (idx == IDX_W'(FRAME_W - 1)) begin
                busy <= 1'b0;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/u9_rx.sv
module u9_rx
    import u9_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxd,
    input  logic     ren,
    output logic     commit,
    output rx_word_t word
);
    localparam int SW  = $clog2(OVERSAMPLE);
    localparam int MID = OVERSAMPLE / 2;

    rx_state_e       state;
    logic [1:0]      sync;
    logic            rxs;
    logic            prev;
    logic [SW-1:0]   scnt;
    logic [IDX_W-1:0] bidx;
    logic [1:0]      votes;
    logic [DATA_W:0] sh;
    logic            bit_v;

    assign rxs   = sync[1];
    assign bit_v = vote3({rxs, votes});

    always_ff @(posedge clk) begin
        if (rst) begin
            sync   <= '1;
            prev   <= 1'b1;
            state  <= RX_HUNT;
            scnt   <= '0;
            bidx   <= '0;
            votes  <= '0;
            sh     <= '0;
            commit <= 1'b0;
            word   <= '0;
        end else begin
            sync   <= {sync[0], rxd};
            commit <= 1'b0;
            if (tick) begin
                prev <= rxs;
                unique case (state)
                    RX_HUNT: begin
                        if (ren && prev && !rxs) begin
                            state <= RX_FRAME;
                            scnt  <= SW'(1);
                            bidx  <= '0;
                        end
                    end
                    RX_FRAME: begin
                        if (scnt == SW'(OVERSAMPLE - 1)) begin
                            scnt <= '0;
                            bidx <= bidx + 1'b1;
                        end else begin
                            scnt <= scnt + 1'b1;
                        end
                        if (scnt == SW'(MID - 1)) votes[0] <= rxs;
                        if (scnt == SW'(MID))     votes[1] <= rxs;
                        if (scnt == SW'(MID + 1)) begin
                            if (bidx == '0) begin
                                // start bit read high: false start
                                if (bit_v) state <= RX_HUNT;
                            end else if (bidx == IDX_W'(FRAME_W - 1)) begin
                                commit <= 1'b1;
                                word   <= '{data: sh[DATA_W-1:0], ninth: sh[DATA_W]};
                                state  <= RX_HUNT;
                            end else begin
                                sh <= {bit_v, sh[DATA_W:1]};
                            end
                        end
                    end
                    default: state <= RX_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/ninebit_uart.sv
module ninebit_uart
    import u9_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int SAMPLE_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic              ctl_sm2,
    input  logic              ctl_tb8,
    input  logic              ctl_smod,
    input  logic              ctl_ren,
    input  logic              ctl_ti,
    input  logic              ctl_ri,
    input  logic              ctl_rb8,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rxd,
    output logic              txd,
    output logic              ti,
    output logic              ri,
    output logic              rb8,
    output logic [DATA_W-1:0] rx_data,
    output logic              irq
);
    ctl_t     cfg;
    logic     tick;
    logic     tx_busy;
    logic     stop_begin;
    logic     commit;
    rx_word_t word;
    logic     accept;

    u9_baud #(.SAMPLE_DIV(SAMPLE_DIV)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .smod (cfg.smod),
        .tick (tick)
    );

    u9_tx #(.OVERSAMPLE(OVERSAMPLE), .SAMPLE_DIV(SAMPLE_DIV)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .start      (tx_we),
        .data       (tx_data),
        .ninth      (cfg.tb8),
        .smod       (cfg.smod),
        .txd        (txd),
        .busy       (tx_busy),
        .stop_begin (stop_begin)
    );

    u9_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .rxd    (rxd),
        .ren    (cfg.ren),
        .commit (commit),
        .word   (word)
    );

    // multiprocessor acceptance: flag free, and filter off or address frame
    assign accept = commit && !ri && (!cfg.sm2 || word.ninth);
    assign irq    = ti | ri;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            ti      <= 1'b0;
            ri      <= 1'b0;
            rb8     <= 1'b0;
            rx_data <= '0;
        end else begin
            if (ctl_we) begin
                cfg <= '{sm2: ctl_sm2, tb8: ctl_tb8, smod: ctl_smod, ren: ctl_ren};
                ti  <= ctl_ti;
                ri  <= ctl_ri;
                rb8 <= ctl_rb8;
            end
            // hardware set takes priority over a software write in the same cycle
            if (stop_begin) ti <= 1'b1;
            if (accept) begin
                ri      <= 1'b1;
                rb8     <= word.ninth;
                rx_data <= word.data;
            end
        end
    end
endmodule

// File: rtl/u9_checker.sv
module u9_checker
    import u9_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ctl_we,
    input logic              txd,
    input logic              ti,
    input logic              ri,
    input logic              rb8,
    input logic [DATA_W-1:0] rx_data,
    input logic              tx_busy
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd); // R1

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> !txd); // R1

    AST_TI_AT_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(ti) && !$past(ctl_we) |-> txd && tx_busy); // R4

    AST_TI_STICKY: assert property (@(posedge clk) disable iff (rst)
        ti && !ctl_we |=> ti); // R5

    AST_RI_STICKY: assert property (@(posedge clk) disable iff (rst)
        ri && !ctl_we |=> ri); // R5

    AST_LOAD_RAISES_RI: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> $rose(ri)); // R6

    AST_HOLD_WHILE_RI: assert property (@(posedge clk) disable iff (rst)
        ri && !ctl_we |=> $stable(rx_data) && $stable(rb8)); // R8
endmodule

bind ninebit_uart u9_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .ctl_we  (ctl_we),
    .txd     (txd),
    .ti      (ti),
    .ri      (ri),
    .rb8     (rb8),
    .rx_data (rx_data),
    .tx_busy (tx_busy)
);

// File: tb/tb_ninebit_uart.sv
`timescale 1ns/1ps
module tb_ninebit_uart;
    localparam int OS = 16;
    localparam int SD = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_we = 0, ctl_sm2 = 0, ctl_tb8 = 0, ctl_smod = 0, ctl_ren = 0;
    logic ctl_ti = 0, ctl_ri = 0, ctl_rb8 = 0;
    logic tx_we = 0;
    logic [7:0] tx_data = '0;
    logic glitch = 1'b0;
    logic rxd, txd, ti, ri, rb8, irq;
    logic [7:0] rx_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cur_bit  = OS * SD * 2;

    always #5 clk = ~clk;

    assign rxd = txd & ~glitch;

    ninebit_uart dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_sm2(ctl_sm2), .ctl_tb8(ctl_tb8),
        .ctl_smod(ctl_smod), .ctl_ren(ctl_ren), .ctl_ti(ctl_ti), .ctl_ri(ctl_ri),
        .ctl_rb8(ctl_rb8), .tx_we(tx_we), .tx_data(tx_data), .rxd(rxd), .txd(txd),
        .ti(ti), .ri(ri), .rb8(rb8), .rx_data(rx_data), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model of the transmit line and the transmit-done flag
    bit         m_busy = 0;
    bit         m_ti   = 0;
    bit         m_tb8  = 0;
    bit         m_smod = 0;
    int         m_t    = 0;
    int         m_bit  = 64;
    logic [10:0] m_frame = '1;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_ti = 0; m_tb8 = 0; m_smod = 0; m_t = 0;
        end else begin
            if (m_busy) begin
                m_t++;
                if (m_t == 11 * m_bit) m_busy = 0;
                else if (m_t == 10 * m_bit) m_ti = 1;
            end else if (tx_we) begin
                m_busy  = 1;
                m_t     = 0;
                m_frame = {1'b1, m_tb8, tx_data, 1'b0};
                m_bit   = m_smod ? OS * SD : 2 * OS * SD;
            end
            if (ctl_we) begin
                m_tb8  = ctl_tb8;
                m_smod = ctl_smod;
                if (!(m_busy && m_t == 10 * m_bit)) m_ti = ctl_ti;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic exp_txd;
            exp_txd = m_busy ? m_frame[m_t / m_bit] : 1'b1;
            check(txd == exp_txd, "R1 R2 txd line", 32'(txd), 32'(exp_txd));
            check(ti == m_ti, "R4 R5 ti flag", 32'(ti), 32'(m_ti));
            check(irq == (ti | ri), "R12 irq", 32'(irq), 32'(ti | ri));
        end
    end

    task automatic wr_ctl(input logic sm2, tb8, smod, ren, ti_v, ri_v);
        @(posedge clk); #1;
        ctl_we = 1; ctl_sm2 = sm2; ctl_tb8 = tb8; ctl_smod = smod; ctl_ren = ren;
        ctl_ti = ti_v; ctl_ri = ri_v; ctl_rb8 = rb8;
        cur_bit = smod ? OS * SD : 2 * OS * SD;
        @(posedge clk); #1;
        ctl_we = 0;
    endtask

    task automatic send(input logic [7:0] d);
        @(posedge clk); #1;
        tx_we = 1; tx_data = d;
        @(posedge clk); #1;
        tx_we = 0;
    endtask

    task automatic wait_frame();
        repeat (11 * cur_bit + 48) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(txd == 1'b1, "R1 reset txd idle", 32'(txd), 1);
        check(ti == 0 && ri == 0, "R5 reset flags", {ti, ri}, 0);
        check(rx_data == 8'h00 && rb8 == 0, "R6 reset buffer", {rx_data, rb8}, 0);

        // R6: filter off, fast rate
        wr_ctl(0, 1, 1, 1, 0, 0);
        send(8'hA5);
        wait_frame();
        check(ri == 1, "R6 ri set", 32'(ri), 1);
        check(rx_data == 8'hA5, "R6 data", 32'(rx_data), 32'hA5);
        check(rb8 == 1, "R6 ninth bit", 32'(rb8), 1);
        check(ti == 1, "R4 ti after frame", 32'(ti), 1);

        // R7: filter on, ninth bit 0 -> dropped
        wr_ctl(1, 0, 1, 1, 0, 0);
        send(8'h3C);
        wait_frame();
        check(ri == 0, "R7 data frame dropped ri", 32'(ri), 0);
        check(rx_data == 8'hA5, "R7 data frame dropped buffer", 32'(rx_data), 32'hA5);
        check(rb8 == 1, "R7 data frame dropped rb8", 32'(rb8), 1);

        // R7: filter on, ninth bit 1 -> accepted
        wr_ctl(1, 1, 1, 1, 0, 0);
        send(8'h5A);
        wait_frame();
        check(ri == 1, "R7 address frame ri", 32'(ri), 1);
        check(rx_data == 8'h5A, "R7 address frame data", 32'(rx_data), 32'h5A);

        // R8: flag still pending -> dropped
        wr_ctl(0, 0, 1, 1, 0, 1);
        send(8'h11);
        wait_frame();
        check(ri == 1, "R8 R5 ri held", 32'(ri), 1);
        check(rx_data == 8'h5A, "R8 buffer held", 32'(rx_data), 32'h5A);
        check(rb8 == 1, "R8 rb8 held", 32'(rb8), 1);

        // R2 slow rate, R3 write during busy ignored
        wr_ctl(0, 0, 0, 1, 0, 0);
        send(8'hC3);
        repeat (3 * cur_bit) @(posedge clk);
        send(8'hFF);
        wait_frame();
        check(ri == 1, "R2 slow rate ri", 32'(ri), 1);
        check(rx_data == 8'hC3, "R3 busy write ignored data", 32'(rx_data), 32'hC3);
        check(rb8 == 0, "R3 ninth bit", 32'(rb8), 0);

        // R9: second frame right after the first
        wr_ctl(0, 1, 0, 1, 0, 0);
        send(8'h96);
        while (ri !== 1'b1) @(negedge clk);
        check(rx_data == 8'h96, "R9 first frame", 32'(rx_data), 32'h96);
        wr_ctl(0, 0, 0, 1, 0, 0);
        repeat (cur_bit) @(posedge clk);
        send(8'h69);
        wait_frame();
        check(ri == 1, "R9 second frame ri", 32'(ri), 1);
        check(rx_data == 8'h69 && rb8 == 0, "R9 second frame", {rx_data, rb8}, {8'h69, 1'b0});

        // R10: short glitch rejected
        wr_ctl(0, 1, 1, 1, 0, 0);
        @(posedge clk); #1 glitch = 1;
        repeat (3) @(posedge clk);
        #1 glitch = 0;
        repeat (4 * cur_bit) @(posedge clk);
        @(negedge clk);
        check(ri == 0, "R10 glitch ri", 32'(ri), 0);
        check(rx_data == 8'h69, "R10 glitch buffer", 32'(rx_data), 32'h69);
        send(8'h42);
        wait_frame();
        check(ri == 1 && rx_data == 8'h42, "R10 frame after glitch", {ri, rx_data}, {1'b1, 8'h42});

        // R11: receive disabled
        wr_ctl(0, 0, 1, 0, 0, 0);
        send(8'h24);
        wait_frame();
        check(ri == 0, "R11 ren off ri", 32'(ri), 0);
        check(rx_data == 8'h42, "R11 ren off buffer", 32'(rx_data), 32'h42);

        finish_run();
    end
endmodule